// File: doc/BRIEF.md
# Three-Channel Compare Interval Timer

This block is an up-counting timer that sits on a simple synchronous register bus. Software selects one of three tick sources and sets a prescale divisor. The counter then advances once for every group of selected ticks while the timer is enabled. Three compare channels watch the counter. Each one raises its own status flag when the counter steps onto the channel's value. A rollover flag is raised when the counter steps onto its all-ones value.

The counter has two modes. In restart mode, channel 1 acts as a period register: the step after a match on it returns the counter to zero, and writing channel 1 zeroes the counter at once. In free-run mode, the counter wraps from all ones to zero. Status bits are cleared by writing ones. A single level interrupt combines the status flags with a per-flag enable mask, and it is active only while the timer is enabled. Two capture slots read as zero.

Top module: `gtmr_top`

## Requirements
- R1: After hard reset, control, prescaler, status, enable mask and counter read 0. All three compare registers read all ones (counter width, default 32 bits), and irq is low.
- R2: Word addresses are: 0 control, 1 prescaler, 2 status, 3 enable mask, 4/5/6 compare 1/2/3, 7/8 capture placeholders, 9 counter. Capture addresses and all other addresses read 0, and writes to them change nothing.
- R3: Control stores only bits 0 (enable), 1 (restart-on-enable), 3, 5, 8:6 (tick select) and 9 (free-run). Every other bit reads 0. Writing bit 15 as 1 performs a soft reset: status, enable mask, prescaler and counter become 0, the compares become all ones, and control keeps only the written bits 8:6 and 9.
- R4: Tick select 001 picks tick_periph, 010 picks tick_fast and 100 picks tick_slow. Every other code picks no tick, and the counter holds.
- R5: While enabled, the counter advances once on every (P+1)-th selected tick, where P is the 12-bit prescaler. A prescaler write, a soft reset or an enable rise restarts the tick grouping.
- R6: With enable at 0, the counter and the tick grouping hold. A write that raises enable with bit 1 also set zeroes the counter. Without bit 1, the counter resumes from its held value.
- R7: In restart mode (bit 9 = 0), a counter step taken while the counter equals compare 1 loads 0. A write to compare 1 in restart mode zeroes the counter in that cycle.
- R8: In free-run mode (bit 9 = 1), a step from all ones loads 0.
- R9: A counter step that lands on compare N sets status bit N-1. A step that lands on all ones sets status bit 5. Status bits 3 and 4 stay 0. Zeroing by write or soft reset sets no flag.
- R10: Writing status clears each bit written as 1 and leaves bits written as 0 unchanged. A flag set in the same cycle as the clear survives.
- R11: irq is high exactly when enable is 1 and (status AND enable mask) is nonzero.
- R12: Reading address 9 returns the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_periph | input | 1 | Tick source picked by code 001 |
| tick_fast | input | 1 | Tick source picked by code 010 |
| tick_slow | input | 1 | Tick source picked by code 100 |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_rdata | output | DATA_W | Read data for bus_addr, same cycle |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check these properties:
- A disabled timer with no bus write keeps its count.
- A restart-mode step at compare 1 and a free-run step at all ones both land on zero.
- Status flags only fall on a status or control write.
- A soft reset empties the flag, mask, prescaler and counter state.
- The tick grouping never runs past the prescaler value.

Only the bench scenarios can show the following:
- Which tick source each select code routes.
- The exact counter value across prescale groups.
- Which flag a given step raises, including coincident compares.
- That a set wins over a same-cycle clear.
- The bit-exact read-back of control after a masked write.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  // word addresses
  localparam int A_CTRL = 0;
  localparam int A_PSC  = 1;
  localparam int A_STAT = 2;
  localparam int A_IEN  = 3;
  localparam int A_CMP1 = 4;
  localparam int A_CNT  = 9;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_RSTEN = 1;
  localparam int CB_SRCLO = 6;
  localparam int CB_FRUN  = 9;
  localparam int CB_SWR   = 15;

  // storable control bits and bits kept through a soft reset
  localparam logic [31:0] CTRL_STORE = 32'h0000_03EB;
  localparam logic [31:0] CTRL_SOFT  = 32'h0000_03C0;

  // tick select codes
  localparam logic [2:0] SRC_PERIPH = 3'b001;
  localparam logic [2:0] SRC_FAST   = 3'b010;
  localparam logic [2:0] SRC_SLOW   = 3'b100;

  localparam int FLAG_W  = 6;
  localparam int FB_ROLL = 5;
  localparam int NUM_CMP = 3;
endpackage

// File: rtl/gtmr_tick_div.sv
module gtmr_tick_div
  import gtmr_pkg::*;
#(
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_sel,
  input  logic [2:0]       tick_in,   // {slow, fast, periph}
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc,
  output logic             step
);
  logic             src_tick;
  logic             phase_end;
  logic             div_en;
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] div_d;

  always_comb begin
    case (src_sel)
      SRC_PERIPH: src_tick = tick_in[0];
      SRC_FAST:   src_tick = tick_in[1];
      SRC_SLOW:   src_tick = tick_in[2];
      default:    src_tick = 1'b0;
    endcase
  end

  always_comb begin
    phase_end = (div_q == psc);
    step      = run & src_tick & phase_end;
    div_en    = clr | (run & src_tick);
    div_d     = (clr | phase_end) ? '0 : div_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= psc); // R5
endmodule

// File: rtl/gtmr_cmp_chan.sv
module gtmr_cmp_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             soft_rst,
  input  logic             step,
  input  logic [CNT_W-1:0] next_cnt,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);
  logic             cmp_en;
  logic [CNT_W-1:0] cmp_d;

  always_comb begin
    cmp_en = wr | soft_rst;
    cmp_d  = soft_rst ? '1 : wdata;
    hit    = step & (next_cnt == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else if (cmp_en) begin
      cmp_q <= cmp_d;
    end
  end

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !soft_rst) |=> $stable(cmp_q)); // R2
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_periph,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [FLAG_W-1:0] sr_q, sr_d, sr_set, sr_clr;
  logic [FLAG_W-1:0] ien_q, ien_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_stepv;
  logic              ctrl_en, psc_en, ien_en, cnt_en;

  logic wr_ctrl, wr_psc, wr_stat, wr_ien;
  logic soft_rst, en_rise, zero_req, div_clr;
  logic en_q, frun_q;
  logic step, step_eff, roll_hit;

  logic [NUM_CMP-1:0] wr_cmp;
  logic [NUM_CMP-1:0] cmp_hit;
  logic [CNT_W-1:0]   cmp_val [NUM_CMP];

  // decode
  always_comb begin
    wr_ctrl  = bus_we && (bus_addr == ADDR_W'(A_CTRL));
    wr_psc   = bus_we && (bus_addr == ADDR_W'(A_PSC));
    wr_stat  = bus_we && (bus_addr == ADDR_W'(A_STAT));
    wr_ien   = bus_we && (bus_addr == ADDR_W'(A_IEN));
    en_q     = ctrl_q[CB_EN];
    frun_q   = ctrl_q[CB_FRUN];
    soft_rst = wr_ctrl && bus_wdata[CB_SWR];
    en_rise  = wr_ctrl && !soft_rst && !en_q && bus_wdata[CB_EN];
    zero_req = soft_rst || (en_rise && bus_wdata[CB_RSTEN]) ||
               (wr_cmp[0] && !frun_q);
    div_clr  = soft_rst || wr_psc || en_rise;
  end

  gtmr_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (ctrl_q[CB_SRCLO +: 3]),
    .tick_in ({tick_slow, tick_fast, tick_periph}),
    .run     (en_q),
    .clr     (div_clr),
    .psc     (psc_q),
    .step    (step)
  );

  // counter next value for a step
  always_comb begin
    cnt_stepv = (!frun_q && (cnt_q == cmp_val[0])) ? '0 : cnt_q + CNT_W'(1);
    step_eff  = step && !zero_req;
    roll_hit  = step_eff && (&cnt_stepv);
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    assign wr_cmp[gi] = bus_we && (bus_addr == ADDR_W'(A_CMP1 + gi));
    gtmr_cmp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_cmp[gi]),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .soft_rst (soft_rst),
      .step     (step_eff),
      .next_cnt (cnt_stepv),
      .cmp_q    (cmp_val[gi]),
      .hit      (cmp_hit[gi])
    );
  end

  // next-state
  always_comb begin
    ctrl_en = wr_ctrl;
    ctrl_d  = soft_rst ? (bus_wdata & DATA_W'(CTRL_SOFT))
                       : (bus_wdata & DATA_W'(CTRL_STORE));
    psc_en  = wr_psc || soft_rst;
    psc_d   = soft_rst ? '0 : bus_wdata[PSC_W-1:0];
    ien_en  = wr_ien || soft_rst;
    ien_d   = soft_rst ? '0 : bus_wdata[FLAG_W-1:0];
    cnt_en  = zero_req || step_eff;
    cnt_d   = zero_req ? '0 : cnt_stepv;

    sr_set = '0;
    sr_set[NUM_CMP-1:0] = cmp_hit;
    sr_set[FB_ROLL]     = roll_hit;
    sr_clr = wr_stat ? bus_wdata[FLAG_W-1:0] : '0;
    sr_d   = soft_rst ? '0 : ((sr_q & ~sr_clr) | sr_set);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      ien_q  <= '0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (psc_en)  psc_q  <= psc_d;
      if (ien_en)  ien_q  <= ien_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      sr_q <= sr_d;
    end
  end

  // outputs
  always_comb begin
    irq = en_q && |(sr_q & ien_q);
    case (bus_addr)
      ADDR_W'(A_CTRL):     bus_rdata = ctrl_q;
      ADDR_W'(A_PSC):      bus_rdata = DATA_W'(psc_q);
      ADDR_W'(A_STAT):     bus_rdata = DATA_W'(sr_q);
      ADDR_W'(A_IEN):      bus_rdata = DATA_W'(ien_q);
      ADDR_W'(A_CMP1):     bus_rdata = DATA_W'(cmp_val[0]);
      ADDR_W'(A_CMP1 + 1): bus_rdata = DATA_W'(cmp_val[1]);
      ADDR_W'(A_CMP1 + 2): bus_rdata = DATA_W'(cmp_val[2]);
      ADDR_W'(A_CNT):      bus_rdata = DATA_W'(cnt_q);
      default:             bus_rdata = '0;
    endcase
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bus_we) |=> $stable(cnt_q)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !frun_q && (cnt_q == cmp_val[0]) && !bus_we) |=> (cnt_q == '0)); // R7
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && frun_q && (&cnt_q) && !bus_we) |=> (cnt_q == '0)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == ADDR_W'(A_STAT) || bus_addr == ADDR_W'(A_CTRL)))
      |=> ((sr_q & $past(sr_q)) == $past(sr_q))); // R10
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == ADDR_W'(A_CTRL)) && bus_wdata[CB_SWR])
      |=> (sr_q == '0 && ien_q == '0 && cnt_q == '0 && psc_q == '0)); // R3
endmodule

// File: tb/gtmr_top_tb.sv
module gtmr_top_tb;
  localparam int CW = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        t_p, t_f, t_s;
  logic [3:0]  b_addr;
  logic [31:0] b_wdata;
  logic        b_we;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  gtmr_top #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_periph(t_p), .tick_fast(t_f),
    .tick_slow(t_s), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_we(b_we), .bus_rdata(rdata), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int tick_mode = 0;  // 0 none, 1 all every cycle, 2 random

  // reference model state
  logic [31:0]   m_ctrl;
  logic [11:0]   m_psc, m_div;
  logic [5:0]    m_sr, m_ien;
  logic [CW-1:0] m_cmp [3];
  logic [CW-1:0] m_cnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = '0; m_psc = '0; m_div = '0; m_sr = '0; m_ien = '0; m_cnt = '0;
    for (int i = 0; i < 3; i++) m_cmp[i] = '1;
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return 32'(m_psc);
      4'd2: return 32'(m_sr);
      4'd3: return 32'(m_ien);
      4'd4: return 32'(m_cmp[0]);
      4'd5: return 32'(m_cmp[1]);
      4'd6: return 32'(m_cmp[2]);
      4'd9: return 32'(m_cnt);
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    logic tick, en, step, swr, rise, zreq, clrdiv;
    logic [CW-1:0] nxt;
    logic [5:0] set;
    en = m_ctrl[0];
    case (m_ctrl[8:6])
      3'b001: tick = t_p;
      3'b010: tick = t_f;
      3'b100: tick = t_s;
      default: tick = 1'b0;
    endcase
    step   = en && tick && (m_div == m_psc);
    swr    = b_we && b_addr == 4'd0 && b_wdata[15];
    rise   = b_we && b_addr == 4'd0 && !swr && !en && b_wdata[0];
    zreq   = swr || (rise && b_wdata[1]) || (b_we && b_addr == 4'd4 && !m_ctrl[9]);
    clrdiv = swr || (b_we && b_addr == 4'd1) || rise;
    nxt = (!m_ctrl[9] && m_cnt == m_cmp[0]) ? '0 : m_cnt + 1'b1;
    set = '0;
    if (step && !zreq) begin
      for (int i = 0; i < 3; i++) if (nxt == m_cmp[i]) set[i] = 1'b1;
      if (&nxt) set[5] = 1'b1;
    end
    if (clrdiv) m_div = '0;
    else if (en && tick) m_div = (m_div == m_psc) ? '0 : m_div + 1'b1;
    if (zreq) m_cnt = '0;
    else if (step) m_cnt = nxt;
    m_sr = (m_sr & ~((b_we && b_addr == 4'd2) ? b_wdata[5:0] : 6'd0)) | set;
    if (b_we) begin
      case (b_addr)
        4'd0: m_ctrl = swr ? (b_wdata & 32'h3C0) : (b_wdata & 32'h3EB);
        4'd1: m_psc = b_wdata[11:0];
        4'd3: m_ien = b_wdata[5:0];
        4'd4: m_cmp[0] = b_wdata[CW-1:0];
        4'd5: m_cmp[1] = b_wdata[CW-1:0];
        4'd6: m_cmp[2] = b_wdata[CW-1:0];
        default: ;
      endcase
    end
    if (swr) begin
      m_sr = '0; m_ien = '0; m_psc = '0;
      for (int i = 0; i < 3; i++) m_cmp[i] = '1;
    end
  endtask

  function automatic string tag_for(input logic [3:0] a, input string cnt_tag);
    case (a)
      4'd0: return "R3";
      4'd1: return "R5";
      4'd2: return "R9";
      4'd3: return "R10";
      4'd9: return cnt_tag;
      default: return "R2";
    endcase
  endfunction

  // one clock: drive ticks, model at the edge, compare at negedge
  task automatic cyc(input string tag);
    case (tick_mode)
      1: begin t_p = 1; t_f = 1; t_s = 1; end
      2: begin t_p = 1'($urandom); t_f = 1'($urandom); t_s = 1'($urandom); end
      default: begin t_p = 0; t_f = 0; t_s = 0; end
    endcase
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag_for(b_addr, tag), rdata, m_read(b_addr));
    chk("R11", 32'(irq), 32'(m_ctrl[0] && |(m_sr & m_ien)));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    b_we = 1; b_addr = a; b_wdata = d;
    cyc(tag);
    b_we = 0; b_addr = 4'd9; b_wdata = '0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp, input string tag);
    b_addr = a;
    #1;
    chk(tag, rdata, exp);
    b_addr = 4'd9;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; b_we = 0; b_addr = 4'd9; b_wdata = '0; t_p = 0; t_f = 0; t_s = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, hand values
    rd_exp(4'd0, 32'h0, "R1"); rd_exp(4'd1, 32'h0, "R1");
    rd_exp(4'd2, 32'h0, "R1"); rd_exp(4'd3, 32'h0, "R1");
    rd_exp(4'd4, 32'hFFF, "R1"); rd_exp(4'd5, 32'hFFF, "R1");
    rd_exp(4'd6, 32'hFFF, "R1"); rd_exp(4'd9, 32'h0, "R1");
    chk("R1", 32'(irq), 32'h0);

    // R3 control mask and soft reset
    wr(4'd0, 32'hFFFF_7FFF, "R3");
    rd_exp(4'd0, 32'h0000_03EB, "R3");
    wr(4'd0, 32'h0000_81C3, "R3");
    rd_exp(4'd0, 32'h0000_01C0, "R3");

    // R2 unknown address and capture slots
    wr(4'd12, 32'hDEAD_BEEF, "R2");
    rd_exp(4'd12, 32'h0, "R2"); rd_exp(4'd7, 32'h0, "R2"); rd_exp(4'd8, 32'h0, "R2");
    wr(4'd7, 32'h1234_5678, "R2");
    rd_exp(4'd7, 32'h0, "R2");

    // R4 tick select: only periph ticks while fast selected, then all
    wr(4'd0, 32'h0000_0283, "R4");          // free-run, src 010, en, restart-on-enable
    t_p = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); model_step(); @(negedge clk);
      chk("R4", rdata, m_read(4'd9));
    end
    rd_exp(4'd9, 32'h0, "R4");
    tick_mode = 1;
    run(6, "R4");
    wr(4'd0, 32'h0000_0382, "R4");          // code 110 picks nothing, disabled
    wr(4'd0, 32'h0000_0381, "R4");          // re-enable with no tick source
    run(6, "R4");

    // R5 prescaler
    wr(4'd0, 32'h0000_0242, "R5");          // disable, src 001
    wr(4'd1, 32'h0000_0002, "R5");
    wr(4'd0, 32'h0000_0243, "R6");          // enable, restart -> count 0
    rd_exp(4'd9, 32'h0, "R6");
    run(12, "R5");
    rd_exp(4'd9, 32'h4, "R5");              // 12 ticks / 3

    // R6 disable freezes, resume without restart
    wr(4'd0, 32'h0000_0240, "R6");
    run(10, "R6");
    wr(4'd0, 32'h0000_0241, "R6");
    run(7, "R6");

    // R7 restart mode period and compare-1 write
    wr(4'd1, 32'h0, "R7");
    wr(4'd3, 32'h0000_0027, "R7");
    wr(4'd0, 32'h0000_0043, "R7");
    wr(4'd4, 32'h0000_0005, "R7");
    wr(4'd5, 32'h0000_0003, "R9");
    run(20, "R7");
    wr(4'd4, 32'h0000_0004, "R7");
    run(12, "R7");

    // R10 write-one-to-clear
    wr(4'd2, 32'h0000_0001, "R10");
    run(2, "R10");
    wr(4'd2, 32'h0000_003F, "R10");
    run(3, "R10");

    // R8/R9 free run through a wrap with coincident compares
    wr(4'd0, 32'h0000_0243, "R8");
    wr(4'd4, 32'h0000_0FF0, "R9");
    wr(4'd5, 32'h0000_0FF0, "R9");
    wr(4'd6, 32'h0000_0000, "R9");
    run(4100, "R8");
    b_addr = 4'd2;
    run(4, "R9");
    b_addr = 4'd9;

    // random mix
    tick_mode = 2;
    for (int n = 0; n < 40000; n++) begin
      if ($urandom_range(7) == 0) begin
        logic [3:0]  a;
        logic [31:0] d;
        a = 4'($urandom_range(11));
        d = $urandom;
        if (a >= 4'd4 && a <= 4'd6) d = 32'($urandom_range(40));
        if (a == 4'd1) d = 32'($urandom_range(3));
        if (a == 4'd0) begin
          d[15] = ($urandom_range(15) == 0);
          if ($urandom_range(3) != 0) d[8:6] = 3'b001 << $urandom_range(2);
          d[0] = ($urandom_range(4) != 0);
        end
        wr(a, d, "R12");
      end else begin
        b_addr = 4'($urandom_range(10));
        cyc("R12");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule